// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads translation descriptors from a two-level table in memory. A lookup starts from a translation base pointer and one first-level entry. That entry maps 1 MB directly, or it points to a second-level table. There are two kinds of second-level table. A coarse table is 1 KB and maps 64 KB and 4 KB pages. A fine table is 4 KB and maps 1 KB pages.

The walker takes one lookup at a time. It issues word reads on a request/grant/response memory port. It reports the result with a one-cycle completion strobe. The result holds:
- the physical address,
- the cacheable and bufferable attributes,
- the 4-bit domain,
- the raw access-permission field,
- a size code,
- or a fault flag and the level that faulted.

The block does not cache translations, check permissions or remap addresses. It only walks the table and decodes what it finds.

Top module: `ptw_walker`

## Requirements
- R1: The first read of every walk goes to {base[31:14], va[31:20], 2'b00}, where base is the table pointer captured when the lookup is accepted.
- R2: A first-level entry with type bits [1:0]=10 is a 1 MB block and completes after exactly one read. In this case pa = {d[31:20], va[19:0]}, bufferable = d[2], cacheable = d[3], domain = d[8:5], ap = {6'b0, d[11:10]} and size code = 0.
- R3: A first-level entry with type bits [1:0]=00 completes after one read with fault=1 and fault level=0.
- R4: A first-level type 01 selects a coarse table. The second read goes to {d1[31:10], va[19:12], 2'b00}. A second-level type 01 there yields pa = {d2[31:16], va[15:0]}, size code 1 and ap = d2[11:4].
- R5: A second-level type 10 in a coarse table yields pa = {d2[31:12], va[11:0]}, size code 2 and ap = d2[11:4]. Bufferable and cacheable come from d2[2] and d2[3]. The domain comes from the first-level d1[8:5].
- R6: A first-level type 11 selects a fine table. The second read goes to {d1[31:12], va[19:10], 2'b00}. A second-level type 11 there yields pa = {d2[31:10], va[9:0]}, size code 3 and ap = {6'b0, d2[5:4]}.
- R7: A second-level entry with type 00 completes after two reads with fault=1 and fault level=1.
- R8: A size that the table kind cannot map is reported as a second-level fault (fault=1, level=1) after two reads. This covers a type 11 in a coarse table, and a type 01 or 10 in a fine table.
- R9: A lookup is accepted only while req_ready_o is high. req_valid_i has no effect during a walk. done_o is high for exactly one cycle per accepted lookup.
- R10: The memory request holds its address stable until it is granted. Every read address is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ttb_i | input | 32 | Table base pointer, sampled when a lookup is accepted |
| req_valid_i | input | 1 | Lookup request |
| req_va_i | input | 32 | Virtual address to translate |
| req_ready_o | output | 1 | Walker idle; a request is taken this cycle |
| mem_req_o | output | 1 | Descriptor read request |
| mem_addr_o | output | 32 | Descriptor byte address |
| mem_gnt_i | input | 1 | Memory has taken the read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Descriptor word |
| done_o | output | 1 | One-cycle completion strobe |
| pa_o | output | 32 | Physical address |
| cacheable_o | output | 1 | Cacheable attribute |
| bufferable_o | output | 1 | Bufferable attribute |
| domain_o | output | 4 | Domain number |
| ap_o | output | 8 | Raw access-permission field |
| size_o | output | 2 | 0 = 1 MB, 1 = 64 KB, 2 = 4 KB, 3 = 1 KB |
| fault_o | output | 1 | Translation fault |
| fault_lvl_o | output | 1 | 0 = first level, 1 = second level |

## Verification
The properties assume four things about the memory side:
- It returns exactly one response for each granted read.
- It never asserts rvalid without an outstanding read.
- It never grants when no request is present.
- The table base and the virtual address do not matter after acceptance.

The bench memory model grants only a raised request. It answers each grant once, with variable grant and response delays. The driver waits for req_ready_o before each lookup. Once a walk is under way, the driver changes only the request valid and the address, which the walker must ignore.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int unsigned WORD_W       = 32;
    localparam int unsigned DOM_W        = 4;
    localparam int unsigned DOM_LSB      = 5;
    localparam int unsigned AP_W         = 8;
    localparam int unsigned BLOCK_SHIFT  = 20;
    localparam int unsigned LARGE_SHIFT  = 16;
    localparam int unsigned SMALL_SHIFT  = 12;
    localparam int unsigned TINY_SHIFT   = 10;
    localparam int unsigned BASE_ALIGN   = 14;
    localparam int unsigned COARSE_ALIGN = 10;
    localparam int unsigned FINE_ALIGN   = 12;
    localparam int unsigned WORD_SHIFT   = 2;

    typedef enum logic [2:0] {
        ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        SZ_BLOCK = 2'd0, SZ_LARGE = 2'd1, SZ_SMALL = 2'd2, SZ_TINY = 2'd3
    } page_size_e;

    typedef enum logic [1:0] {
        K1_FAULT = 2'd0, K1_COARSE = 2'd1, K1_BLOCK = 2'd2, K1_FINE = 2'd3
    } l1_kind_e;

    typedef struct packed {
        logic [WORD_W-1:0] pa;
        logic              cacheable;
        logic              bufferable;
        logic [DOM_W-1:0]  domain;
        logic [AP_W-1:0]   ap;
        page_size_e        size;
        logic              fault;
        logic              fault_l2;
    } walk_result_t;

    // Upper bits from hi (above sh), lower bits from lo.
    function automatic logic [WORD_W-1:0] join_addr(input logic [WORD_W-1:0] hi,
                                                    input logic [WORD_W-1:0] lo,
                                                    input int unsigned sh);
        logic [WORD_W-1:0] m;
        m = {WORD_W{1'b1}} << sh;
        return (hi & m) | (lo & ~m);
    endfunction

    // Table index taken from va[top-1:low], scaled to a word offset.
    function automatic logic [WORD_W-1:0] word_index(input logic [WORD_W-1:0] va,
                                                     input int unsigned top,
                                                     input int unsigned low);
        logic [WORD_W-1:0] m;
        m = ~({WORD_W{1'b1}} << (top - low));
        return ((va >> low) & m) << WORD_SHIFT;
    endfunction

endpackage

// File: rtl/ptw_l1_decode.sv
module ptw_l1_decode
    import ptw_pkg::*;
(
    input  logic [WORD_W-1:0] desc_i,
    input  logic [WORD_W-1:0] va_i,
    output l1_kind_e          kind_o,
    output walk_result_t      block_res_o,
    output logic [WORD_W-1:0] l2_addr_o,
    output logic [DOM_W-1:0]  domain_o
);
    logic [WORD_W-1:0] coarse_addr;
    logic [WORD_W-1:0] fine_addr;

    always_comb begin
        kind_o   = l1_kind_e'(desc_i[1:0]);
        domain_o = desc_i[DOM_LSB +: DOM_W];

        coarse_addr = join_addr(desc_i, word_index(va_i, BLOCK_SHIFT, SMALL_SHIFT), COARSE_ALIGN);
        fine_addr   = join_addr(desc_i, word_index(va_i, BLOCK_SHIFT, TINY_SHIFT), FINE_ALIGN);
        l2_addr_o   = (kind_o == K1_FINE) ? fine_addr : coarse_addr;

        block_res_o            = '0;
        block_res_o.pa         = join_addr(desc_i, va_i, BLOCK_SHIFT);
        block_res_o.bufferable = desc_i[2];
        block_res_o.cacheable  = desc_i[3];
        block_res_o.domain     = desc_i[DOM_LSB +: DOM_W];
        block_res_o.ap         = {{(AP_W-2){1'b0}}, desc_i[11:10]};
        block_res_o.size       = SZ_BLOCK;
    end
endmodule

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
    import ptw_pkg::*;
(
    input  logic [WORD_W-1:0] desc_i,
    input  logic [WORD_W-1:0] va_i,
    input  logic              fine_i,
    input  logic [DOM_W-1:0]  domain_i,
    output walk_result_t      res_o
);
    page_size_e kind;
    logic       legal;

    always_comb begin
        kind = page_size_e'(desc_i[1:0]);
        // Coarse tables carry 64K/4K pages; fine tables carry 1K pages.
        legal = fine_i ? (kind == SZ_TINY)
                       : (kind == SZ_LARGE || kind == SZ_SMALL);

        res_o = '0;
        if (!legal) begin
            res_o.fault    = 1'b1;
            res_o.fault_l2 = 1'b1;
        end else begin
            res_o.bufferable = desc_i[2];
            res_o.cacheable  = desc_i[3];
            res_o.domain     = domain_i;
            res_o.size       = kind;
            case (kind)
                SZ_LARGE: begin
                    res_o.pa = join_addr(desc_i, va_i, LARGE_SHIFT);
                    res_o.ap = desc_i[11:4];
                end
                SZ_SMALL: begin
                    res_o.pa = join_addr(desc_i, va_i, SMALL_SHIFT);
                    res_o.ap = desc_i[11:4];
                end
                default: begin
                    res_o.pa = join_addr(desc_i, va_i, TINY_SHIFT);
                    res_o.ap = {{(AP_W-2){1'b0}}, desc_i[5:4]};
                end
            endcase
        end
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] ttb_i,
    input  logic              req_valid_i,
    input  logic [WORD_W-1:0] req_va_i,
    output logic              req_ready_o,
    output logic              mem_req_o,
    output logic [WORD_W-1:0] mem_addr_o,
    input  logic              mem_gnt_i,
    input  logic              mem_rvalid_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              done_o,
    output logic [WORD_W-1:0] pa_o,
    output logic              cacheable_o,
    output logic              bufferable_o,
    output logic [DOM_W-1:0]  domain_o,
    output logic [AP_W-1:0]   ap_o,
    output logic [1:0]        size_o,
    output logic              fault_o,
    output logic              fault_lvl_o
);
    typedef struct packed {
        walk_state_e       state;
        logic [WORD_W-1:0] va;
        logic [WORD_W-1:0] maddr;
        logic [DOM_W-1:0]  domain;
        logic              fine;
        walk_result_t      res;
    } walk_regs_t;

    walk_regs_t q, d;

    l1_kind_e          l1_kind;
    walk_result_t      l1_block_res;
    logic [WORD_W-1:0] l1_next_addr;
    logic [DOM_W-1:0]  l1_domain;
    walk_result_t      l2_res;

    ptw_l1_decode u_l1 (
        .desc_i      (mem_rdata_i),
        .va_i        (q.va),
        .kind_o      (l1_kind),
        .block_res_o (l1_block_res),
        .l2_addr_o   (l1_next_addr),
        .domain_o    (l1_domain)
    );

    ptw_l2_decode u_l2 (
        .desc_i   (mem_rdata_i),
        .va_i     (q.va),
        .fine_i   (q.fine),
        .domain_i (q.domain),
        .res_o    (l2_res)
    );

    always_comb begin
        d = q;
        case (q.state)
            ST_IDLE: begin
                if (req_valid_i) begin
                    d.va    = req_va_i;
                    d.maddr = join_addr(ttb_i, word_index(req_va_i, WORD_W, BLOCK_SHIFT), BASE_ALIGN);
                    d.state = ST_L1_REQ;
                end
            end
            ST_L1_REQ: if (mem_gnt_i) d.state = ST_L1_WAIT;
            ST_L1_WAIT: begin
                if (mem_rvalid_i) begin
                    case (l1_kind)
                        K1_FAULT: begin
                            d.res          = '0;
                            d.res.fault    = 1'b1;
                            d.res.fault_l2 = 1'b0;
                            d.state        = ST_DONE;
                        end
                        K1_BLOCK: begin
                            d.res   = l1_block_res;
                            d.state = ST_DONE;
                        end
                        default: begin
                            d.maddr  = l1_next_addr;
                            d.domain = l1_domain;
                            d.fine   = (l1_kind == K1_FINE);
                            d.state  = ST_L2_REQ;
                        end
                    endcase
                end
            end
            ST_L2_REQ: if (mem_gnt_i) d.state = ST_L2_WAIT;
            ST_L2_WAIT: begin
                if (mem_rvalid_i) begin
                    d.res   = l2_res;
                    d.state = ST_DONE;
                end
            end
            ST_DONE: d.state = ST_IDLE;
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign req_ready_o  = (q.state == ST_IDLE);
    assign mem_req_o    = (q.state == ST_L1_REQ) || (q.state == ST_L2_REQ);
    assign mem_addr_o   = q.maddr;
    assign done_o       = (q.state == ST_DONE);
    assign pa_o         = q.res.pa;
    assign cacheable_o  = q.res.cacheable;
    assign bufferable_o = q.res.bufferable;
    assign domain_o     = q.res.domain;
    assign ap_o         = q.res.ap;
    assign size_o       = q.res.size;
    assign fault_o      = q.res.fault;
    assign fault_lvl_o  = q.res.fault_l2;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
    import ptw_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] ttb_i,
    input logic              req_valid_i,
    input logic [WORD_W-1:0] req_va_i,
    input logic              req_ready_o,
    input logic              mem_req_o,
    input logic [WORD_W-1:0] mem_addr_o,
    input logic              mem_gnt_i,
    input logic              done_o,
    input logic [1:0]        size_o,
    input logic              fault_o,
    input logic              fault_lvl_o
);
    logic [1:0]        rd_cnt;
    logic [WORD_W-1:0] ttb_l;
    logic [WORD_W-1:0] va_l;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt <= '0;
            ttb_l  <= '0;
            va_l   <= '0;
        end else if (req_valid_i && req_ready_o) begin
            rd_cnt <= '0;
            ttb_l  <= ttb_i;
            va_l   <= req_va_i;
        end else if (mem_req_o && mem_gnt_i && rd_cnt != 2'd3) begin
            rd_cnt <= rd_cnt + 2'd1;
        end
    end

    assert_first_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && rd_cnt == 2'd0) |-> mem_addr_o == {ttb_l[31:14], va_l[31:20], 2'b00});
    assert_block_reads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fault_o && size_o == 2'd0) |-> rd_cnt == 2'd1);
    assert_l1_fault_reads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o && !fault_lvl_o) |-> rd_cnt == 2'd1);
    assert_page_reads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fault_o && size_o != 2'd0) |-> rd_cnt == 2'd2);
    assert_l2_fault_reads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o && fault_lvl_o) |-> rd_cnt == 2'd2);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> !req_ready_o);
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o)));
    assert_word_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> mem_addr_o[1:0] == 2'b00);
endmodule

bind ptw_walker ptw_walker_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ttb_i       (ttb_i),
    .req_valid_i (req_valid_i),
    .req_va_i    (req_va_i),
    .req_ready_o (req_ready_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_gnt_i   (mem_gnt_i),
    .done_o      (done_o),
    .size_o      (size_o),
    .fault_o     (fault_o),
    .fault_lvl_o (fault_lvl_o)
);

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ttb_i = '0;
    logic        req_valid_i = 1'b0;
    logic [31:0] req_va_i = '0;
    logic        req_ready_o;
    logic        mem_req_o;
    logic [31:0] mem_addr_o;
    logic        mem_gnt_i = 1'b0;
    logic        mem_rvalid_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;
    logic        done_o;
    logic [31:0] pa_o;
    logic        cacheable_o, bufferable_o;
    logic [3:0]  domain_o;
    logic [7:0]  ap_o;
    logic [1:0]  size_o;
    logic        fault_o, fault_lvl_o;

    always #4 clk = ~clk;

    ptw_walker dut (.*);

    typedef struct {
        string       tag;
        logic [31:0] a1, a2;
        int          nrd;
        logic [31:0] pa;
        logic        c, b;
        logic [3:0]  dom;
        logic [7:0]  ap;
        logic [1:0]  sz;
        logic        flt, lvl;
    } exp_t;

    logic [31:0] mem [logic [31:0]];
    exp_t        exp_q[$];
    logic [31:0] obs_q[$];
    int errors = 0, checks = 0, done_cnt = 0, issued = 0, rd_seq = 0;
    bit finished = 0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic exp_t ref_walk(input logic [31:0] ttb, input logic [31:0] va);
        exp_t e;
        logic [31:0] d1, d2;
        logic fine;
        e = '{tag: "", a1: '0, a2: '0, nrd: 1, pa: '0, c: 0, b: 0, dom: '0, ap: '0, sz: '0, flt: 0, lvl: 0};
        e.a1 = {ttb[31:14], va[31:20], 2'b00};
        d1 = rd(e.a1);
        case (d1[1:0])
            2'b00: e.flt = 1;
            2'b10: begin
                e.pa = {d1[31:20], va[19:0]}; e.c = d1[3]; e.b = d1[2];
                e.dom = d1[8:5]; e.ap = {6'b0, d1[11:10]}; e.sz = 2'd0;
            end
            default: begin
                fine = (d1[1:0] == 2'b11);
                e.a2 = fine ? {d1[31:12], va[19:10], 2'b00} : {d1[31:10], va[19:12], 2'b00};
                e.nrd = 2;
                d2 = rd(e.a2);
                if (d2[1:0] == 2'b00 || (fine && d2[1:0] != 2'b11) || (!fine && d2[1:0] == 2'b11)) begin
                    e.flt = 1; e.lvl = 1;
                end else begin
                    e.dom = d1[8:5]; e.c = d2[3]; e.b = d2[2]; e.sz = d2[1:0];
                    case (d2[1:0])
                        2'b01: begin e.pa = {d2[31:16], va[15:0]}; e.ap = d2[11:4]; end
                        2'b10: begin e.pa = {d2[31:12], va[11:0]}; e.ap = d2[11:4]; end
                        default: begin e.pa = {d2[31:10], va[9:0]}; e.ap = {6'b0, d2[5:4]}; end
                    endcase
                end
            end
        endcase
        return e;
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Memory model: variable grant and response latency.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_o) begin
                repeat (rd_seq % 3) @(negedge clk);
                mem_gnt_i = 1'b1;
                obs_q.push_back(mem_addr_o);
                @(negedge clk);
                mem_gnt_i = 1'b0;
                repeat ((rd_seq / 3) % 2) @(negedge clk);
                mem_rvalid_i = 1'b1;
                mem_rdata_i  = rd(obs_q[obs_q.size()-1]);
                rd_seq++;
                @(negedge clk);
                mem_rvalid_i = 1'b0;
                mem_rdata_i  = '0;
            end
        end
    end

    // Monitor / scoreboard
    logic prev_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done) check("R9", "done width", {31'b0, done_o}, 32'h0);
            if (done_o) begin
                done_cnt++;
                if (exp_q.size() == 0) begin
                    check("R9", "unexpected done", 32'h1, 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(e.tag, "read count", obs_q.size(), e.nrd);
                    if (obs_q.size() > 0) check("R1", "first read addr", obs_q[0], e.a1);
                    if (e.nrd == 2 && obs_q.size() > 1) check(e.tag, "second read addr", obs_q[1], e.a2);
                    check(e.tag, "fault", {30'b0, fault_o, fault_lvl_o}, {30'b0, e.flt, e.lvl});
                    if (!e.flt) begin
                        check(e.tag, "pa", pa_o, e.pa);
                        check(e.tag, "attrs", {16'b0, cacheable_o, bufferable_o, domain_o, ap_o, size_o},
                              {16'b0, e.c, e.b, e.dom, e.ap, e.sz});
                    end
                end
                obs_q.delete();
            end
            prev_done <= done_o;
        end
    end

    task automatic walk(input logic [31:0] ttb, input logic [31:0] va, input string tag, input bit hold);
        exp_t e;
        while (!req_ready_o) @(negedge clk);
        ttb_i = ttb; req_va_i = va;
        e = ref_walk(ttb, va);
        e.tag = tag;
        exp_q.push_back(e);
        issued++;
        req_valid_i = 1'b1;
        @(negedge clk);
        if (hold) begin
            // R9: valid kept high with another address while busy
            req_va_i = va ^ 32'h0F0F_0000;
            check("R9", "ready while busy", {31'b0, req_ready_o}, 32'h0);
            repeat (2) @(negedge clk);
        end
        req_valid_i = 1'b0;
        while (done_cnt < issued) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    localparam logic [31:0] TA = 32'h0001_C000;
    localparam logic [31:0] TB = 32'h8000_4000;

    initial begin
        // Table A, first level
        mem[TA + 32'h123*4] = 32'hABC0_0CAA;   // block, C=1 B=0 dom 5 ap 3
        mem[TA + 32'hFFF*4] = 32'h0000_05E6;   // block, C=0 B=1 dom F ap 1
        mem[TA + 32'h200*4] = 32'h0040_0461;   // coarse at 0x00400400, dom 3
        mem[TA + 32'h300*4] = 32'h0080_1143;   // fine at 0x00801000, dom A
        // Coarse table entries
        mem[32'h0040_0400 + 32'h34*4] = 32'h7777_0E4D;   // large
        mem[32'h0040_0400 + 32'h35*4] = 32'h5555_51BA;   // small
        mem[32'h0040_0400 + 32'h36*4] = 32'h3333_3003;   // tiny in coarse
        // Fine table entries
        mem[32'h0080_1000 + 32'h2AF*4] = 32'h9999_9C37;  // tiny
        mem[32'h0080_1000 + 32'h001*4] = 32'h4444_4002;  // small in fine
        mem[32'h0080_1000 + 32'h002*4] = 32'h2222_0001;  // large in fine
        // Table B
        mem[TB + 32'h001*4] = 32'h1230_0C02;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "reset ready", {31'b0, req_ready_o}, 32'h1);
        check("R9", "reset done", {31'b0, done_o}, 32'h0);
        check("R10", "reset mem_req", {31'b0, mem_req_o}, 32'h0);

        walk(TA, 32'h1234_5678, "R2", 0);
        walk(TA, 32'hFFFF_FFFF, "R2", 0);
        walk(TA, 32'h0000_0000, "R3", 0);
        walk(TA, 32'h2003_4ABC, "R4", 0);
        walk(TA, 32'h2003_5123, "R5", 0);
        walk(TA, 32'h2003_7000, "R7", 0);
        walk(TA, 32'h2003_6FFF, "R8", 0);
        walk(TA, 32'h300A_BCDE, "R6", 0);
        walk(TA, 32'h3000_0400, "R8", 0);
        walk(TA, 32'h3000_0800, "R8", 0);
        walk(TB, 32'h001F_0F0F, "R1", 0);
        walk(TA, 32'h2003_5FFF, "R9", 1);
        walk(TA, 32'h1230_0000, "R9", 1);
        walk(TA, 32'h300A_BC00, "R10", 0);
        repeat (10) @(negedge clk);
        check("R9", "pending results", exp_q.size(), 32'h0);
        finish_run();
    end
endmodule